// File: doc/BRIEF.md
# Audio Ring Buffer Pointer Controller

This block keeps the pointer state for one circular audio buffer held in system memory. Software sets where the buffer starts and ends, loads the read and write pointers, and chooses a byte threshold. A data mover on the hardware side then asks to advance one pointer by N bytes. In playback the mover consumes data at the read pointer. In capture it produces data at the write pointer. The block itself moves no data.

Every pointer has one phase bit above its byte address. This bit tells a full buffer apart from an empty one without a spare slot. When a pointer runs past the last byte, it returns to the base and flips its phase bit. The block reports the filled byte count, empty and full flags, and the position of the active pointer relative to the base. It also keeps a sticky threshold flag. The flag is set once the free space (playback) or the filled space (capture) goes strictly above the threshold. It stays set until software writes the rearm register.

The advance port uses valid/ready. `adv_ready` drops in any cycle in which software writes a pointer register. An advance presented in such a cycle is held off and must stay valid. When valid and ready are both high, the request is taken. If it asks for more bytes than the buffer can give (playback) or hold (capture), it is refused instead of applied.

Top module: `audio_ring_ptr`

## Requirements
- R1: Register selects on `reg_sel` are 0 base, 1 end (last valid byte), 2 read pointer, 3 write pointer, 4 threshold and 5 rearm (write only, reads 0). After reset every readable register is 0, the buffer reports empty with a level of 0, and `adv_ready` is 1.
- R2: `empty_o` is 1 exactly when both pointers are equal including the phase bit (the MSB). `full_o` is 1 exactly when the address bits are equal and the phase bits differ.
- R3: `level_o` gives the filled bytes. This is write address minus read address when the phases match, and otherwise buffer size minus (read address minus write address). The buffer size is end minus base plus 1.
- R4: An accepted advance moves the read pointer by N bytes in playback (`play_mode`=1) and the write pointer in capture. The move takes effect at the clock edge that accepts the request.
- R5: A pointer that an advance carries past the end address continues from the base and flips its phase bit.
- R6: An advance is refused when N is larger than the filled bytes (playback) or the free bytes (capture). A refused advance leaves both pointers unchanged and raises `adv_err` for exactly one cycle, in the cycle after it was accepted.
- R7: A software pointer write wins over an advance. `adv_ready` is 0 in that cycle, the written value is stored, and the advance is not applied.
- R8: `mark_flag` rises one cycle after the free bytes (playback) or the filled bytes (capture) become strictly greater than the threshold. Equality does not set it.
- R9: Once set, `mark_flag` stays set until a write to select 5. That write clears it at its edge. If the condition still holds, the flag sets again one cycle later.
- R10: The threshold has a granularity of 256 bytes. The low 8 bits of a written value are dropped and read back as 0.
- R11: `cur_pos` equals the active pointer's address bits minus the base (the read pointer in playback, the write pointer in capture).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_mode | input | 1 | 1 = playback (read pointer advances), 0 = capture |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | ADDR_W+1 | Register write data |
| reg_rdata | output | ADDR_W+1 | Register read data for `reg_sel` |
| adv_valid | input | 1 | Advance request valid |
| adv_ready | output | 1 | Advance request can be taken this cycle |
| adv_bytes | input | CNT_W | Bytes to advance |
| adv_err | output | 1 | One-cycle pulse for a refused advance |
| level_o | output | ADDR_W+1 | Filled bytes |
| cur_pos | output | ADDR_W | Active pointer offset from base |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| mark_flag | output | 1 | Sticky threshold flag |

## Verification
The bench builds the block with a 12-bit address and a 13-bit advance count. This keeps every pointer, level and phase value small enough to model as plain integers. It sweeps both modes over three buffer sizes, two base offsets, and advance sizes that range from an odd count up to the whole buffer. Together these cover wraps that land exactly on the base, full and empty states on equal addresses, and refusals at the limit. Directed cases then cover the threshold boundary, rearm with the condition still true, threshold granularity, and a pointer write that meets an advance in the same cycle.

// File: rtl/audio_ring_pkg.sv
package audio_ring_pkg;
  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_END   = 3'd1,
    SEL_RDPTR = 3'd2,
    SEL_WRPTR = 3'd3,
    SEL_MARK  = 3'd4,
    SEL_REARM = 3'd5
  } ring_sel_e;

  localparam int unsigned MARK_GRAN_LG = 8;
endpackage

// File: rtl/audio_ring_step.sv
module audio_ring_step #(
  parameter int unsigned ADDR_W = 31,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [ADDR_W:0]   ptr_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W:0]   ptr_o
);
  localparam int unsigned SW = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 2;

  logic [SW-1:0] sum, endx, size, wrapped;

  always_comb begin
    sum     = SW'(ptr_i[ADDR_W-1:0]) + SW'(n_i);
    endx    = SW'(end_i);
    size    = endx - SW'(base_i) + SW'(1);
    wrapped = sum - size;
    if (sum > endx) ptr_o = {~ptr_i[ADDR_W], wrapped[ADDR_W-1:0]};
    else            ptr_o = {ptr_i[ADDR_W], sum[ADDR_W-1:0]};
  end
endmodule

// File: rtl/audio_ring_level.sv
module audio_ring_level #(
  parameter int unsigned ADDR_W = 31
) (
  input  logic [ADDR_W:0]   rd_i,
  input  logic [ADDR_W:0]   wr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W:0]   fill_o,
  output logic [ADDR_W:0]   free_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [ADDR_W:0] size, rd_a, wr_a;
  logic            same_phase, same_addr;

  always_comb begin
    rd_a       = {1'b0, rd_i[ADDR_W-1:0]};
    wr_a       = {1'b0, wr_i[ADDR_W-1:0]};
    size       = {1'b0, end_i} - {1'b0, base_i} + 1'b1;
    same_phase = (rd_i[ADDR_W] == wr_i[ADDR_W]);
    same_addr  = (rd_a == wr_a);
    if (same_phase) fill_o = wr_a - rd_a;
    else            fill_o = size - (rd_a - wr_a);
    free_o  = size - fill_o;
    empty_o = same_addr && same_phase;
    full_o  = same_addr && !same_phase;
  end
endmodule

// File: rtl/audio_ring_mark.sv
module audio_ring_mark #(
  parameter int unsigned MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] metric_i,
  input  logic [MW-1:0] mark_i,
  input  logic          rearm_i,
  output logic          flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                flag_o <= 1'b0;
    else if (rearm_i)          flag_o <= 1'b0;
    else if (metric_i > mark_i) flag_o <= 1'b1;
  end

  // R8
  mark_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(metric_i > mark_i));

  // R9
  mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !rearm_i) |=> flag_o);
endmodule

// File: rtl/audio_ring_ptr.sv
module audio_ring_ptr
  import audio_ring_pkg::*;
#(
  parameter int unsigned ADDR_W = 31,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_mode,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W:0]   reg_wdata,
  output logic [ADDR_W:0]   reg_rdata,
  input  logic              adv_valid,
  output logic              adv_ready,
  input  logic [CNT_W-1:0]  adv_bytes,
  output logic              adv_err,
  output logic [ADDR_W:0]   level_o,
  output logic [ADDR_W-1:0] cur_pos,
  output logic              empty_o,
  output logic              full_o,
  output logic              mark_flag
);
  localparam int unsigned CMPW = ((CNT_W > ADDR_W + 1) ? CNT_W : ADDR_W + 1);

  logic [ADDR_W-1:0] base_q, end_q, mark_q;
  logic [ADDR_W:0]   rd_q, wr_q, act_ptr, next_ptr;
  logic [ADDR_W:0]   fill, free, avail, metric;
  logic              sw_rd_we, sw_wr_we, sw_ptr_we, rearm;
  logic              take, apply, refuse;

  always_comb begin
    sw_rd_we  = reg_we && (reg_sel == SEL_RDPTR);
    sw_wr_we  = reg_we && (reg_sel == SEL_WRPTR);
    sw_ptr_we = sw_rd_we || sw_wr_we;
    rearm     = reg_we && (reg_sel == SEL_REARM);
    adv_ready = !sw_ptr_we;
    take      = adv_valid && adv_ready;
    act_ptr   = play_mode ? rd_q : wr_q;
    avail     = play_mode ? fill : free;
    apply     = take && (CMPW'(adv_bytes) <= CMPW'(avail));
    refuse    = take && !apply;
    metric    = play_mode ? free : fill;
  end

  audio_ring_level #(.ADDR_W(ADDR_W)) u_level (
    .rd_i(rd_q), .wr_i(wr_q), .base_i(base_q), .end_i(end_q),
    .fill_o(fill), .free_o(free), .empty_o(empty_o), .full_o(full_o)
  );

  audio_ring_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
    .ptr_i(act_ptr), .n_i(adv_bytes), .base_i(base_q), .end_i(end_q),
    .ptr_o(next_ptr)
  );

  audio_ring_mark #(.MW(ADDR_W + 1)) u_mark (
    .clk(clk), .rst_n(rst_n), .metric_i(metric), .mark_i({1'b0, mark_q}),
    .rearm_i(rearm), .flag_o(mark_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      end_q   <= '0;
      mark_q  <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      adv_err <= 1'b0;
    end else begin
      adv_err <= refuse;
      if (reg_we && reg_sel == SEL_BASE) base_q <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_sel == SEL_END)  end_q  <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_sel == SEL_MARK)
        mark_q <= {reg_wdata[ADDR_W-1:MARK_GRAN_LG], {MARK_GRAN_LG{1'b0}}};
      if (sw_rd_we)                rd_q <= reg_wdata;
      else if (apply && play_mode) rd_q <= next_ptr;
      if (sw_wr_we)                 wr_q <= reg_wdata;
      else if (apply && !play_mode) wr_q <= next_ptr;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_BASE:  reg_rdata = {1'b0, base_q};
      SEL_END:   reg_rdata = {1'b0, end_q};
      SEL_RDPTR: reg_rdata = rd_q;
      SEL_WRPTR: reg_rdata = wr_q;
      SEL_MARK:  reg_rdata = {1'b0, mark_q};
      default:   reg_rdata = '0;
    endcase
    level_o = fill;
    cur_pos = act_ptr[ADDR_W-1:0] - base_q;
  end

  // R7
  sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_sel == SEL_RDPTR) |-> (rd_q == $past(reg_wdata)));

  // R6
  refuse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_err |-> ($stable(rd_q) && $stable(wr_q)));

  // R5
  wrap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sw_rd_we) && (rd_q[ADDR_W] != $past(rd_q[ADDR_W])))
      |-> (rd_q[ADDR_W-1:0] <= $past(rd_q[ADDR_W-1:0])));
endmodule

// File: tb/audio_ring_ptr_tb.sv
module audio_ring_ptr_tb;
  localparam int AW    = 12;
  localparam int CW    = 13;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          play_mode = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [AW:0]   reg_wdata = '0;
  logic [AW:0]   reg_rdata;
  logic          adv_valid = 1'b0;
  logic          adv_ready;
  logic [CW-1:0] adv_bytes = '0;
  logic          adv_err;
  logic [AW:0]   level_o;
  logic [AW-1:0] cur_pos;
  logic          empty_o, full_o, mark_flag;

  int checks = 0;
  int errors = 0;

  int          m_base, m_size, m_mark;
  logic [AW:0] m_rd, m_wr;
  bit          m_play, m_flag;

  audio_ring_ptr #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .play_mode(play_mode), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adv_valid(adv_valid), .adv_ready(adv_ready), .adv_bytes(adv_bytes),
    .adv_err(adv_err), .level_o(level_o), .cur_pos(cur_pos),
    .empty_o(empty_o), .full_o(full_o), .mark_flag(mark_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input int sel, output int val);
    reg_sel = 3'(sel);
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic write_reg(input int sel, input int data);
    reg_we    = 1'b1;
    reg_sel   = 3'(sel);
    reg_wdata = (AW+1)'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int fill_m();
    int ra = int'(m_rd[AW-1:0]);
    int wa = int'(m_wr[AW-1:0]);
    if (m_rd[AW] == m_wr[AW]) return wa - ra;
    return m_size - (ra - wa);
  endfunction

  function automatic int metric_m();
    return m_play ? (m_size - fill_m()) : fill_m();
  endfunction

  function automatic logic [AW:0] step_m(input logic [AW:0] p, input int n);
    int a = int'(p[AW-1:0]) + n;
    if (a >= m_base + m_size) return {~p[AW], AW'(a - m_size)};
    return {p[AW], AW'(a)};
  endfunction

  task automatic verify_all();
    int v;
    int act;
    read_reg(2, v); check("R4/R5 read pointer", v, int'(m_rd));
    read_reg(3, v); check("R4/R5 write pointer", v, int'(m_wr));
    check("R3 level", int'(level_o), fill_m());
    check("R2 empty", int'(empty_o), int'(m_rd == m_wr));
    check("R2 full", int'(full_o),
          int'(m_rd[AW-1:0] == m_wr[AW-1:0] && m_rd[AW] != m_wr[AW]));
    act = m_play ? int'(m_rd[AW-1:0]) : int'(m_wr[AW-1:0]);
    check("R11 position", int'(cur_pos), (act - m_base) & ((1 << AW) - 1));
    check("R8 threshold flag", int'(mark_flag), int'(m_flag));
  endtask

  task automatic rearm_and_settle();
    write_reg(5, 0);
    check("R9 cleared at rearm", int'(mark_flag), 0);
    @(negedge clk);
    m_flag = (metric_m() > m_mark);
    verify_all();
  endtask

  task automatic configure(input bit play, input int base, input int size, input int mark);
    m_play = play; m_base = base; m_size = size; m_mark = mark;
    play_mode = play;
    m_rd = (AW+1)'(base);
    m_wr = play ? {1'b1, AW'(base)} : (AW+1)'(base);
    write_reg(0, base);
    write_reg(1, base + size - 1);
    write_reg(4, mark);
    write_reg(2, int'(m_rd));
    write_reg(3, int'(m_wr));
    rearm_and_settle();
  endtask

  task automatic advance(input int n, output bit refused);
    int avail;
    adv_valid = 1'b1;
    adv_bytes = CW'(n);
    #1;
    check("R7 ready without pointer write", int'(adv_ready), 1);
    @(negedge clk);
    adv_valid = 1'b0;
    avail = m_play ? fill_m() : (m_size - fill_m());
    refused = (n > avail);
    check("R6 error pulse", int'(adv_err), int'(refused));
    if (!refused) begin
      if (m_play) m_rd = step_m(m_rd, n);
      else        m_wr = step_m(m_wr, n);
    end
    @(negedge clk);
    check("R6 error lasts one cycle", int'(adv_err), 0);
    if (metric_m() > m_mark) m_flag = 1'b1;
    verify_all();
  endtask

  task automatic service();
    if (m_play) begin
      m_wr = {~m_rd[AW], m_rd[AW-1:0]};
      write_reg(3, int'(m_wr));
    end else begin
      m_rd = m_wr;
      write_reg(2, int'(m_rd));
    end
    rearm_and_settle();
  endtask

  initial begin
    int v;
    bit refused;
    int sizes[3] = '{256, 768, 1024};
    int bases[2] = '{0, 'h340};
    int steps[4] = '{37, 256, 300, 0};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      read_reg(s, v);
      check("R1 register after reset", v, 0);
    end
    check("R1 empty after reset", int'(empty_o), 1);
    check("R1 full after reset", int'(full_o), 0);
    check("R1 level after reset", int'(level_o), 0);
    check("R1 ready after reset", int'(adv_ready), 1);
    check("R1 flag after reset", int'(mark_flag), 0);
    @(negedge clk);

    // sweep: R3 R4 R5 R6 R11 in both modes
    for (int md = 0; md < 2; md++) begin
      for (int si = 0; si < 3; si++) begin
        for (int bi = 0; bi < 2; bi++) begin
          for (int st = 0; st < 4; st++) begin
            int n = (steps[st] == 0) ? sizes[si] : steps[st];
            configure(md == 0, bases[bi], sizes[si], (sizes[si] / 2) & ~255);
            for (int it = 0; it < 12; it++) begin
              advance(n, refused);
              if (refused) service();
            end
          end
        end
      end
    end

    // R8 strict threshold, capture
    configure(1'b0, 'h100, 512, 256);
    advance(256, refused);
    check("R8 equal does not set", int'(mark_flag), 0);
    advance(1, refused);
    check("R8 above sets", int'(mark_flag), 1);
    // R9 sticky and rearm with condition still true
    advance(100, refused);
    check("R9 stays set", int'(mark_flag), 1);
    write_reg(5, 0);
    check("R9 clear on rearm", int'(mark_flag), 0);
    @(negedge clk);
    check("R9 fires again", int'(mark_flag), 1);
    m_flag = 1'b1;
    service();
    check("R9 rearm after service", int'(mark_flag), 0);

    // R10 granularity
    write_reg(4, 'h3FF);
    read_reg(4, v);
    check("R10 low bits dropped", v, 'h300);
    write_reg(4, 256);

    // R7 pointer write against advance in the same cycle
    advance(40, refused);
    reg_we    = 1'b1;
    reg_sel   = 3'd2;
    reg_wdata = m_wr;
    adv_valid = 1'b1;
    adv_bytes = CW'(10);
    #1;
    check("R7 ready low during pointer write", int'(adv_ready), 0);
    @(negedge clk);
    reg_we = 1'b0;
    adv_valid = 1'b0;
    m_rd = m_wr;
    check("R7 no error", int'(adv_err), 0);
    @(negedge clk);
    verify_all();

    summary();
    $finish;
  end
endmodule